// File: doc/BRIEF.md
# Two-Level Correlating Branch Direction Predictor

This block guesses whether a conditional branch will be taken. A small global history register holds the outcomes of the most recent resolved branches. Each row of a counter table is chosen by the low-order bits of the branch address and holds one 2-bit saturating counter for every possible history pattern. The current history picks which counter of the row supplies the guess. With the default two history bits, every address row has four counters. The lookup is combinational: a fetch stage presents a PC and reads the taken/not-taken guess in the same cycle.

When the branch resolves, the execute stage presents the branch PC, the actual outcome and a valid strobe. The rising clock edge then moves the counter chosen by that PC and the current history one step toward the outcome, and shifts the outcome into the history. The update port is a plain strobe with no back-pressure: every cycle with `upd_valid` high is accepted. A lookup made in the same cycle as an update sees the state from before that update. Setting `HIST_BITS` to 0 removes the history, and the block becomes a plain table of one 2-bit counter per address row.

Top module: `corr_bpred`

## Requirements
- R1: The table row is `pc[PC_LSB +: IDX_BITS]` (bits 7:2 by default). Two PCs that differ only outside this field share all counters of one row.
- R2: `lk_ctr` shows the counter chosen by `lk_pc` and the current history, combinationally in the same cycle. `lk_taken` is 1 exactly when that counter is 2 or 3.
- R3: On an accepted update, the chosen counter goes up by one for a taken outcome and down by one for a not-taken outcome, holding at 3 and at 0. A strongly biased guess therefore flips only after two mispredictions in the same direction.
- R4: On each accepted update, the history shifts left by one, takes the outcome (1 = taken) into bit 0 and drops its top bit. It is visible on `ghist`.
- R5: While `upd_valid` is low, no counter and no history bit changes, whatever `upd_pc` and `upd_taken` hold.
- R6: An update changes only the counter at (row of `upd_pc`, history before the edge). The other counters of that row and all other rows keep their values.
- R7: While reset is high and after its release, every counter reads 1 (weakly not taken) and the history reads 0.
- R8: An update is registered. A lookup in the same cycle returns the old counter, and the new value is visible from the next cycle on.
- R9: With `HIST_BITS` = 0, `ghist` stays 0 and each row has exactly one counter, which all updates to that row share.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| lk_pc | input | PC_W | Address of the branch being predicted |
| lk_taken | output | 1 | Predicted direction, 1 = taken |
| lk_ctr | output | 2 | Value of the counter chosen for the lookup |
| upd_valid | input | 1 | Resolved-branch strobe |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Actual outcome, 1 = taken |
| ghist | output | max(HIST_BITS,1) | Global outcome history, newest outcome in bit 0 |

## Verification
A wrong history bit changes which counter a row offers. It appears on `ghist` at the clock edge after the faulty update, and it moves `lk_ctr` as soon as a lookup hits a row whose counters differ. A counter that is corrupted, stepped the wrong way or written at the wrong row stays hidden until a lookup reaches that exact row and history pattern. The bench therefore drives the lookup and the update at the same address for long stretches, and compares every counter read against a behavioural model on every cycle. A second instance with no history bits is compared to its own model in parallel.

// File: rtl/bp_pkg.sv
package bp_pkg;
  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_RESET = 2'd1;
  localparam ctr_t CTR_MAX   = 2'd3;
  localparam ctr_t CTR_MIN   = 2'd0;

  // One saturating step toward the resolved outcome
  function automatic ctr_t ctr_step(ctr_t c, logic taken);
    if (taken) return (c == CTR_MAX) ? c : c + 2'd1;
    else       return (c == CTR_MIN) ? c : c - 2'd1;
  endfunction

  // Upper half of the counter range means "taken"
  function automatic logic ctr_dir(ctr_t c);
    return c[1];
  endfunction
endpackage

// File: rtl/bp_ghist.sv
module bp_ghist #(
  parameter int HIST_BITS = 2,
  parameter int HW        = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          upd_valid,
  input  logic          upd_taken,
  output logic [HW-1:0] hist
);
  generate
    if (HIST_BITS > 0) begin : g_hist
      logic [HW-1:0] hist_q;
      always_ff @(posedge clk) begin
        if (rst)            hist_q <= '0;
        else if (upd_valid) hist_q <= HW'({hist_q, upd_taken});
      end
      assign hist = hist_q;
    end else begin : g_nohist
      logic unused_hist_in;
      assign unused_hist_in = ^{clk, rst, upd_valid, upd_taken};
      assign hist = '0;
    end
  endgenerate
endmodule

// File: rtl/bp_index.sv
module bp_index #(
  parameter int PC_W      = 32,
  parameter int PC_LSB    = 2,
  parameter int IDX_BITS  = 6,
  parameter int HIST_BITS = 2,
  parameter int HW        = 2
) (
  input  logic [PC_W-1:0]               pc,
  input  logic [HW-1:0]                 hist,
  output logic [IDX_BITS+HIST_BITS-1:0] addr
);
  logic [IDX_BITS-1:0] row;
  logic                unused_pc;

  assign row       = pc[PC_LSB +: IDX_BITS];
  assign unused_pc = ^pc;

  generate
    if (HIST_BITS > 0) begin : g_corr
      assign addr = {row, hist};
    end else begin : g_flat
      logic unused_h;
      assign unused_h = ^hist;
      assign addr     = row;
    end
  endgenerate
endmodule

// File: rtl/bp_ctr_table.sv
module bp_ctr_table #(
  parameter int AW = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] rd_addr,
  output bp_pkg::ctr_t  rd_ctr,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic          wr_taken
);
  bp_pkg::ctr_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= bp_pkg::CTR_RESET;
    end else if (wr_en) begin
      mem[wr_addr] <= bp_pkg::ctr_step(mem[wr_addr], wr_taken);
    end
  end

  assign rd_ctr = mem[rd_addr];
endmodule

// File: rtl/corr_bpred.sv
module corr_bpred #(
  parameter int PC_W      = 32,
  parameter int PC_LSB    = 2,
  parameter int IDX_BITS  = 6,
  parameter int HIST_BITS = 2,
  localparam int HW = (HIST_BITS > 0) ? HIST_BITS : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] lk_pc,
  output logic            lk_taken,
  output logic [1:0]      lk_ctr,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken,
  output logic [HW-1:0]   ghist
);
  localparam int AW = IDX_BITS + HIST_BITS;

  logic [AW-1:0] rd_addr;
  logic [AW-1:0] wr_addr;

  bp_ghist #(.HIST_BITS(HIST_BITS), .HW(HW)) u_hist (
    .clk(clk), .rst(rst), .upd_valid(upd_valid), .upd_taken(upd_taken), .hist(ghist)
  );

  bp_index #(.PC_W(PC_W), .PC_LSB(PC_LSB), .IDX_BITS(IDX_BITS),
             .HIST_BITS(HIST_BITS), .HW(HW)) u_rd_ix (
    .pc(lk_pc), .hist(ghist), .addr(rd_addr)
  );

  bp_index #(.PC_W(PC_W), .PC_LSB(PC_LSB), .IDX_BITS(IDX_BITS),
             .HIST_BITS(HIST_BITS), .HW(HW)) u_wr_ix (
    .pc(upd_pc), .hist(ghist), .addr(wr_addr)
  );

  bp_ctr_table #(.AW(AW)) u_tab (
    .clk(clk), .rst(rst),
    .rd_addr(rd_addr), .rd_ctr(lk_ctr),
    .wr_en(upd_valid), .wr_addr(wr_addr), .wr_taken(upd_taken)
  );

  assign lk_taken = bp_pkg::ctr_dir(lk_ctr);
endmodule

// File: rtl/bp_chk.sv
module bp_chk #(
  parameter int PC_W      = 32,
  parameter int PC_LSB    = 2,
  parameter int IDX_BITS  = 6,
  parameter int HIST_BITS = 2,
  parameter int HW        = 2
) (
  input logic            clk,
  input logic            rst,
  input logic [PC_W-1:0] lk_pc,
  input logic [1:0]      lk_ctr,
  input logic            upd_valid,
  input logic [PC_W-1:0] upd_pc,
  input logic            upd_taken,
  input logic [HW-1:0]   ghist
);
  logic same_row;
  logic unused_chk;
  assign same_row   = lk_pc[PC_LSB +: IDX_BITS] == upd_pc[PC_LSB +: IDX_BITS];
  assign unused_chk = ^{lk_pc, upd_pc};

  // R7: state right after reset release
  a_r7_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (lk_ctr == 2'd1 && ghist == '0));

  // R5: idle cycles leave history untouched
  a_r5_hold_hist: assert property (@(posedge clk) disable iff (rst)
    !upd_valid |=> $stable(ghist));

  // R5: idle cycles leave the looked-up counter untouched
  a_r5_hold_ctr: assert property (@(posedge clk) disable iff (rst)
    !upd_valid |=> (!$stable(lk_pc) || $stable(lk_ctr)));

  // R3: taken step with history all ones keeps the same counter selected
  a_r3_step_up: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && upd_taken && same_row && ghist == {HW{1'b1}})
    |=> (!$stable(lk_pc) || lk_ctr == bp_pkg::ctr_step($past(lk_ctr), 1'b1)));

  // R3: not-taken step with history all zeros keeps the same counter selected
  a_r3_step_dn: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && !upd_taken && same_row && ghist == '0)
    |=> (!$stable(lk_pc) || lk_ctr == bp_pkg::ctr_step($past(lk_ctr), 1'b0)));

  generate
    if (HIST_BITS > 0) begin : g_shift
      // R4: outcome enters at bit 0
      a_r4_hist_shift: assert property (@(posedge clk) disable iff (rst)
        upd_valid |=> ghist == HW'({$past(ghist), $past(upd_taken)}));
    end else begin : g_flat
      // R9: no history without history bits
      a_r9_no_hist: assert property (@(posedge clk) disable iff (rst)
        ghist == '0);
    end
  endgenerate
endmodule

bind corr_bpred bp_chk #(
  .PC_W(PC_W), .PC_LSB(PC_LSB), .IDX_BITS(IDX_BITS), .HIST_BITS(HIST_BITS), .HW(HW)
) u_chk (
  .clk(clk), .rst(rst), .lk_pc(lk_pc), .lk_ctr(lk_ctr), .upd_valid(upd_valid),
  .upd_pc(upd_pc), .upd_taken(upd_taken), .ghist(ghist)
);

// File: tb/sim_corr_bpred.sv
`timescale 1ns/1ps
module sim_corr_bpred;
  localparam int ROWS = 64;
  localparam int NH   = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] lk_pc = '0;
  logic [31:0] upd_pc = '0;
  logic        upd_valid = 1'b0;
  logic        upd_taken = 1'b0;
  logic        t0, t1;
  logic [1:0]  c0, c1;
  logic [1:0]  h0;
  logic        h1;

  int checks = 0;
  int fails  = 0;
  int ctr_a [ROWS*NH];
  int ctr_b [ROWS];
  int hist_a;
  string tag;

  always #5 clk = ~clk;

  corr_bpred #(.HIST_BITS(2)) u0 (
    .clk(clk), .rst(rst), .lk_pc(lk_pc), .lk_taken(t0), .lk_ctr(c0),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken), .ghist(h0)
  );

  corr_bpred #(.HIST_BITS(0)) u1 (
    .clk(clk), .rst(rst), .lk_pc(lk_pc), .lk_taken(t1), .lk_ctr(c1),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken), .ghist(h1)
  );

  function automatic int row_of(logic [31:0] pc);
    return int'((pc >> 2) & 32'(ROWS - 1));
  endfunction

  function automatic int step(int c, logic t);
    if (t) return (c == 3) ? 3 : c + 1;
    return (c == 0) ? 0 : c - 1;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < ROWS*NH; i++) ctr_a[i] = 1;
    for (int i = 0; i < ROWS; i++) ctr_b[i] = 1;
    hist_a = 0;
  endtask

  task automatic cyc(logic [31:0] lpc, logic v, logic [31:0] upc, logic t);
    int ea, eb;
    @(negedge clk);
    lk_pc = lpc; upd_valid = v; upd_pc = upc; upd_taken = t;
    #1;
    ea = ctr_a[row_of(lpc)*NH + hist_a];
    eb = ctr_b[row_of(lpc)];
    check(tag, "u0 lk_ctr", int'(c0), ea);
    check(tag, "u0 lk_taken", int'(t0), (ea >= 2) ? 1 : 0);
    check(tag, "u0 ghist", int'(h0), hist_a);
    check("R9", "u1 lk_ctr", int'(c1), eb);
    check("R9", "u1 lk_taken", int'(t1), (eb >= 2) ? 1 : 0);
    check("R9", "u1 ghist", int'(h1), 0);
    @(posedge clk);
    if (v) begin
      ctr_a[row_of(upc)*NH + hist_a] = step(ctr_a[row_of(upc)*NH + hist_a], t);
      ctr_b[row_of(upc)] = step(ctr_b[row_of(upc)], t);
      hist_a = ((hist_a << 1) | int'(t)) & (NH - 1);
    end
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] pa, pb, pc;
    pa = 32'h0000_1040;
    pb = 32'h0000_20a4;
    pc = 32'h0000_3010;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R7: reset contents at several rows
    tag = "R7";
    for (int i = 0; i < 4; i++) cyc(32'(i * 52), 1'b0, 32'h0, 1'b1);

    // R3: saturate up, then walk down past the flip point to zero
    tag = "R3";
    for (int i = 0; i < 6; i++) cyc(pa, 1'b1, pa, 1'b1);
    for (int i = 0; i < 7; i++) cyc(pa, 1'b1, pa, 1'b0);

    // R4: alternating outcomes move the history through its patterns
    tag = "R4";
    for (int i = 0; i < 8; i++) cyc(pb, 1'b1, pb, logic'(i % 2));

    // R5: strobe low with busy data inputs
    tag = "R5";
    for (int i = 0; i < 8; i++) cyc(pb, 1'b0, pb, logic'($urandom_range(1)));

    // R1: aliased addresses share one row
    tag = "R1";
    for (int i = 0; i < 6; i++) cyc(pa, 1'b1, pa + 32'((i + 1) * 256), 1'b1);

    // R6: hammer one row, observe its neighbours and the row itself
    tag = "R6";
    for (int i = 0; i < 12; i++) cyc((i % 3 == 0) ? pc : pc + 32'((i % 3) * 4), 1'b1, pc, logic'(i % 4 != 0));

    // R8: update and lookup hit the same address in the same cycle
    tag = "R8";
    for (int i = 0; i < 50; i++) begin
      logic [31:0] p;
      p = 32'($urandom_range(15)) << 2;
      cyc(p, 1'b1, p, logic'($urandom_range(1)));
    end

    // R2: mixed random traffic over a small address set
    tag = "R2";
    for (int i = 0; i < 2000; i++) begin
      logic [31:0] lp, up;
      lp = 32'($urandom_range(31)) << 2;
      up = ($urandom_range(3) == 0) ? lp : (32'($urandom_range(31)) << 2);
      cyc(lp, logic'($urandom_range(3) != 0), up, logic'($urandom_range(4) != 0));
    end

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule